// File: doc/BRIEF.md
# Real-Time Clock Calendar Update Engine

This block is the counting core of a real-time clock. It stores seconds, minutes, hours, day of week, day of month, month, year and century, plus four alarm bytes that are matched against the seconds, minutes, hours and day of month. A one-second tick from an external divider starts an update sequence. The sequence steps through the fields one per clock, carrying from seconds up to century. In its last step it compares the new time against the alarm bytes and latches a sticky alarm flag.

Software reaches the block through a small register port with a combinational read. A control register selects the data format (BCD or binary), the hour mode (12 or 24 hour), gates the divider, and holds a freeze bit that lets software load the time safely. A status register shows whether an update is running and whether the alarm has fired. Reading the status register clears the alarm flag.

The update sequencer is a state machine with these states:
- `S_IDLE`: waits for a tick.
- `S_SEC`, `S_MIN`, `S_HOUR`, `S_DOW`, `S_DATE`, `S_MONTH`, `S_YEAR`, `S_CENT`: each updates one field.
- `S_CMP`: runs the alarm compare.

The sequencer moves as follows:
- `S_IDLE` goes to `S_SEC` on a tick that is accepted.
- Each field state goes to the next field state in the order listed above.
- `S_CENT` goes to `S_CMP`.
- `S_CMP` goes back to `S_IDLE`.
- From any state, a control write that sets the freeze bit returns the machine to `S_IDLE`.

Top module: `rtc_update_engine`

## Requirements
- R1: After reset, the following values hold:

  | Address | Register | Reset value |
  |---|---|---|
  | 0 | seconds | 00h |
  | 1 | minutes | 00h |
  | 2 | hours | 00h |
  | 3 | day of week | 01h |
  | 4 | day of month | 01h |
  | 5 | month | 01h |
  | 6 | year | 00h |
  | 7 | century | 00h |
  | 8–11 | alarm bytes | 00h |
  | 12 | control | 00h |
  | 13 | status | 00h |

  In addition, `upd_busy` and `alarm_irq` are 0 after reset.
- R2: A tick starts an update only when the freeze bit (control bit 7) is 0 and the divider field (control bits 6:4) is nonzero. An update keeps `upd_busy` high for exactly 9 clocks, starting the clock after the tick is sampled.
- R3: Seconds and minutes count 0–59. A field at 59 wraps to 0 and carries into the next field. Control bit 2 selects the format: 1 means binary, 0 means packed BCD (tens in bits 7:4, units in bits 3:0).
- R4: In 24-hour mode (control bit 1 = 1), hours count 0–23. A wrap of hours carries into the day of month. The same carry steps the day of week, which counts 1–7 and wraps from 7 to 1.
- R5: In 12-hour mode (control bit 1 = 0), hours run 1–12 and bit 7 marks PM. The sequence is:
  - 12 advances to 1 and keeps the same AM/PM half.
  - 11 AM advances to 12 PM.
  - 11 PM advances to 12 AM and carries into the date.
- R6: The day of month wraps to 1 after the last day of the month. February has 29 days when the year is divisible by 4 and 28 otherwise. Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0 and carries into the century, and century 99 wraps to 0.
- R7: A control write with bit 7 set ends an update in progress by the next clock. The field that would have been written at that edge is left unchanged. While the freeze bit is set, ticks are ignored.
- R8: During an update, reads of addresses 0–11 return FFh. Status bit 7 reads as 1 during an update.
- R9: At the end of each update, the alarm flag (status bit 0, output `alarm_irq`) is set when each of the seconds, minutes, hours and day-of-month alarm bytes either equals its time byte or is a don't-care value. A don't-care value is any byte from C0h to FFh. The alarm bytes sit at addresses 8, 9, 10 and 11 respectively.
- R10: A status read (`bus_re` with address 13) clears the alarm flag at the next clock. When the compare sets the flag in that same clock, the flag stays set.
- R11: Writes to addresses 0–11 made during an update are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-clock pulse per second from the divider |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; used only to clear the alarm flag on a status read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| upd_busy | output | 1 | High while an update sequence runs |
| alarm_irq | output | 1 | Sticky alarm flag |

## Verification
Two pairs of events can land in the same clock.

The first pair is the alarm compare in `S_CMP` setting the flag and a status read clearing it. The bench counts clocks from the tick and places the status read exactly on the compare cycle. It then expects the flag to survive, and to clear on the following read.

The second pair is a field update and a software access. The bench issues a freeze write or a seconds write on the first clock of the update. It judges the result from the seconds value read back afterwards: unchanged for the abort, incremented for the dropped write.

Sweeps over every month, leap and non-leap years, both data formats and all 24 hours in 12-hour mode are compared against calendar arithmetic done in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned NUM_TIME = 8;
    localparam int unsigned NUM_ALM  = 4;

    localparam int unsigned T_SEC  = 0;
    localparam int unsigned T_MIN  = 1;
    localparam int unsigned T_HOUR = 2;
    localparam int unsigned T_DOW  = 3;
    localparam int unsigned T_DATE = 4;
    localparam int unsigned T_MON  = 5;
    localparam int unsigned T_YEAR = 6;
    localparam int unsigned T_CENT = 7;

    localparam int unsigned A_ALM_BASE = 8;
    localparam int unsigned A_CTRL     = 12;
    localparam int unsigned A_STAT     = 13;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SEC,
        S_MIN,
        S_HOUR,
        S_DOW,
        S_DATE,
        S_MONTH,
        S_YEAR,
        S_CENT,
        S_CMP
    } upd_state_t;

    // Stored byte to plain binary value.
    function automatic logic [7:0] to_bin(input logic [7:0] v, input logic is_bin);
        logic [7:0] tens;
        tens = {4'd0, v[7:4]} * 8'd10;
        return is_bin ? v : (tens + {4'd0, v[3:0]});
    endfunction

    // Plain binary value (0..99) to stored byte.
    function automatic logic [7:0] from_bin(input logic [7:0] v, input logic is_bin);
        logic [7:0] q;
        logic [7:0] r;
        q = v / 8'd10;
        r = v % 8'd10;
        return is_bin ? v : {q[3:0], r[3:0]};
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
        logic [7:0] d;
        case (mon)
            8'd2:                        d = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:     d = 8'd30;
            default:                     d = 8'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_update_fsm.sv
module rtc_update_fsm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    output upd_state_t state,
    output logic       busy
);

    upd_state_t state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (abort) begin
            state_nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  if (start) state_nxt = S_SEC;
                S_SEC:   state_nxt = S_MIN;
                S_MIN:   state_nxt = S_HOUR;
                S_HOUR:  state_nxt = S_DOW;
                S_DOW:   state_nxt = S_DATE;
                S_DATE:  state_nxt = S_MONTH;
                S_MONTH: state_nxt = S_YEAR;
                S_YEAR:  state_nxt = S_CENT;
                S_CENT:  state_nxt = S_CMP;
                S_CMP:   state_nxt = S_IDLE;
                default: state_nxt = S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy = (state != S_IDLE);
    end

    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == S_IDLE));

    // R2
    cmp_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CMP) |=> !busy);

endmodule

// File: rtl/rtc_field_step.sv
module rtc_field_step
    import rtc_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic              is_bin,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic              cin,
    output logic [DATA_W-1:0] nxt,
    output logic              cout
);

    logic [DATA_W-1:0] val;

    always_comb begin
        val  = to_bin(cur, is_bin);
        nxt  = cur;
        cout = 1'b0;
        if (cin) begin
            if (val >= hi) begin
                nxt  = from_bin(lo, is_bin);
                cout = 1'b1;
            end else begin
                nxt  = from_bin(val + 8'd1, is_bin);
            end
        end
    end

endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step
    import rtc_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic              is_bin,
    input  logic              h24,
    input  logic              cin,
    output logic [DATA_W-1:0] nxt,
    output logic              cout
);

    logic [DATA_W-1:0] val;
    logic [DATA_W-1:0] hv;
    logic [DATA_W-1:0] enc;
    logic              pm;

    always_comb begin
        nxt  = cur;
        cout = 1'b0;
        pm   = cur[7];
        hv   = 8'd0;
        enc  = 8'd0;
        val  = h24 ? to_bin(cur, is_bin) : to_bin({1'b0, cur[6:0]}, is_bin);
        if (cin) begin
            if (h24) begin
                if (val >= 8'd23) begin
                    nxt  = from_bin(8'd0, is_bin);
                    cout = 1'b1;
                end else begin
                    nxt  = from_bin(val + 8'd1, is_bin);
                end
            end else begin
                if (val >= 8'd12) begin
                    hv = 8'd1;
                end else if (val == 8'd11) begin
                    hv   = 8'd12;
                    cout = pm;
                    pm   = ~pm;
                end else begin
                    hv = val + 8'd1;
                end
                enc = from_bin(hv, is_bin);
                nxt = {pm, enc[6:0]};
            end
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
#(
    parameter int unsigned N = NUM_ALM
) (
    input  logic [N*DATA_W-1:0] alm_flat,
    input  logic [N*DATA_W-1:0] tim_flat,
    output logic                hit
);

    logic [N-1:0] field_ok;

    for (genvar i = 0; i < N; i++) begin : g_field
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] t;
        assign a = alm_flat[i*DATA_W +: DATA_W];
        assign t = tim_flat[i*DATA_W +: DATA_W];
        assign field_ok[i] = (a[7:6] == 2'b11) || (a == t);
    end

    assign hit = &field_ok;

endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              upd_busy,
    output logic              alarm_irq
);

    localparam logic [ADDR_W-1:0] ADDR_ALM = ADDR_W'(A_ALM_BASE);
    localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] ADDR_STA = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(A_ALM_BASE + NUM_ALM);

    logic [DATA_W-1:0] time_q [NUM_TIME];
    logic [DATA_W-1:0] alm_q  [NUM_ALM];
    logic              ctl_set, ctl_bin, ctl_h24;
    logic [2:0]        ctl_div;
    logic              alarm_q;
    logic              carry_q;

    upd_state_t        state;
    logic              busy;
    logic              start;
    logic              abort;

    logic [2:0]        fs_idx;
    logic [DATA_W-1:0] fs_cur, fs_lo, fs_hi, fs_nxt;
    logic              fs_cin, fs_cout, fs_en;
    logic [DATA_W-1:0] hr_nxt;
    logic              hr_cout;
    logic [DATA_W-1:0] mon_len;
    logic              alm_hit;

    assign abort = bus_we && (bus_addr == ADDR_CTL) && bus_wdata[7];
    assign start = sec_tick && !ctl_set && (ctl_div != 3'd0);

    rtc_update_fsm i_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .abort (abort),
        .state (state),
        .busy  (busy)
    );

    assign mon_len = month_days(to_bin(time_q[T_MON], ctl_bin),
                                to_bin(time_q[T_YEAR], ctl_bin));

    // Field selection for the shared incrementer.
    always_comb begin
        fs_en  = 1'b1;
        fs_idx = 3'(T_SEC);
        fs_lo  = 8'd0;
        fs_hi  = 8'd59;
        fs_cin = carry_q;
        unique case (state)
            S_SEC:   begin fs_idx = 3'(T_SEC);  fs_cin = 1'b1; end
            S_MIN:   begin fs_idx = 3'(T_MIN);  end
            S_DOW:   begin fs_idx = 3'(T_DOW);  fs_lo = 8'd1; fs_hi = 8'd7;  end
            S_DATE:  begin fs_idx = 3'(T_DATE); fs_lo = 8'd1; fs_hi = mon_len; end
            S_MONTH: begin fs_idx = 3'(T_MON);  fs_lo = 8'd1; fs_hi = 8'd12; end
            S_YEAR:  begin fs_idx = 3'(T_YEAR); fs_hi = 8'd99; end
            S_CENT:  begin fs_idx = 3'(T_CENT); fs_hi = 8'd99; end
            default: begin fs_en = 1'b0; fs_cin = 1'b0; end
        endcase
        fs_cur = time_q[fs_idx];
    end

    rtc_field_step i_field_step (
        .cur    (fs_cur),
        .is_bin (ctl_bin),
        .lo     (fs_lo),
        .hi     (fs_hi),
        .cin    (fs_cin),
        .nxt    (fs_nxt),
        .cout   (fs_cout)
    );

    rtc_hour_step i_hour_step (
        .cur    (time_q[T_HOUR]),
        .is_bin (ctl_bin),
        .h24    (ctl_h24),
        .cin    (carry_q),
        .nxt    (hr_nxt),
        .cout   (hr_cout)
    );

    rtc_alarm_match #(.N(NUM_ALM)) i_alarm_match (
        .alm_flat ({alm_q[3], alm_q[2], alm_q[1], alm_q[0]}),
        .tim_flat ({time_q[T_DATE], time_q[T_HOUR], time_q[T_MIN], time_q[T_SEC]}),
        .hit      (alm_hit)
    );

    // Time, calendar and alarm storage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_TIME; i++) begin
                time_q[i] <= 8'h00;
            end
            time_q[T_DOW]  <= 8'h01;
            time_q[T_DATE] <= 8'h01;
            time_q[T_MON]  <= 8'h01;
            for (int i = 0; i < NUM_ALM; i++) begin
                alm_q[i] <= 8'h00;
            end
            carry_q <= 1'b0;
        end else if (busy) begin
            if (!abort) begin
                if (state == S_HOUR) begin
                    time_q[T_HOUR] <= hr_nxt;
                    carry_q        <= hr_cout;
                end else if (fs_en) begin
                    time_q[fs_idx] <= fs_nxt;
                    if (state != S_DOW) begin
                        carry_q <= fs_cout;
                    end
                end
            end
        end else if (bus_we) begin
            if (bus_addr < ADDR_ALM) begin
                time_q[bus_addr[2:0]] <= bus_wdata;
            end else if (bus_addr < ADDR_END) begin
                alm_q[bus_addr[1:0]] <= bus_wdata;
            end
        end
    end

    // Control register: writable at any time.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_set <= 1'b0;
            ctl_div <= 3'd0;
            ctl_bin <= 1'b0;
            ctl_h24 <= 1'b0;
        end else if (bus_we && (bus_addr == ADDR_CTL)) begin
            ctl_set <= bus_wdata[7];
            ctl_div <= bus_wdata[6:4];
            ctl_bin <= bus_wdata[2];
            ctl_h24 <= bus_wdata[1];
        end
    end

    // Sticky alarm flag: compare sets, status read clears, set wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
        end else if ((state == S_CMP) && !abort && alm_hit) begin
            alarm_q <= 1'b1;
        end else if (bus_re && (bus_addr == ADDR_STA)) begin
            alarm_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr < ADDR_ALM) begin
            bus_rdata = busy ? 8'hFF : time_q[bus_addr[2:0]];
        end else if (bus_addr < ADDR_END) begin
            bus_rdata = busy ? 8'hFF : alm_q[bus_addr[1:0]];
        end else if (bus_addr == ADDR_CTL) begin
            bus_rdata = {ctl_set, ctl_div, 1'b0, ctl_bin, ctl_h24, 1'b0};
        end else if (bus_addr == ADDR_STA) begin
            bus_rdata = {busy, 6'b0, alarm_q};
        end
    end

    assign upd_busy  = busy;
    assign alarm_irq = alarm_q;

    // R2
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (ctl_set || (ctl_div == 3'd0))) |=> !busy);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_IDLE) && !(bus_we && (bus_addr == '0))) |=> $stable(time_q[T_SEC]));

    // R3
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_SEC) && ctl_bin && (time_q[T_SEC] < 8'd59) && !abort)
        |=> (time_q[T_SEC] == $past(time_q[T_SEC]) + 8'd1));

    // R9
    alarm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_q) |-> ($past(state) == S_CMP));

    // R10
    alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q && bus_re && (bus_addr == ADDR_STA) && (state != S_CMP)) |=> !alarm_q);

endmodule

// File: tb/test_rtc_update_engine.sv
module test_rtc_update_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       upd_busy;
    logic       alarm_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rtc_update_engine i_rtc_update_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .upd_busy  (upd_busy),
        .alarm_irq (alarm_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input int v, input bit bin);
        return bin ? 8'(v) : {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_of(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] e);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, e);
    endtask

    task automatic read_status(output logic [7:0] d);
        @(negedge clk);
        bus_addr = 4'd13;
        bus_re   = 1'b1;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_re   = 1'b0;
    endtask

    task automatic tick_wait();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        repeat (9) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] s, m, h, w, d, mo, y, c);
        wr(4'd0, s); wr(4'd1, m); wr(4'd2, h); wr(4'd3, w);
        wr(4'd4, d); wr(4'd5, mo); wr(4'd6, y); wr(4'd7, c);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] st;
        int cnt;
        int y, dm, d, ed, emo, ey, ec, h, hn, bin;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        expect_reg("R1 sec", 4'd0, 8'h00);
        expect_reg("R1 min", 4'd1, 8'h00);
        expect_reg("R1 hour", 4'd2, 8'h00);
        expect_reg("R1 dow", 4'd3, 8'h01);
        expect_reg("R1 date", 4'd4, 8'h01);
        expect_reg("R1 month", 4'd5, 8'h01);
        expect_reg("R1 year", 4'd6, 8'h00);
        expect_reg("R1 century", 4'd7, 8'h00);
        for (int a = 8; a < 12; a++) expect_reg("R1 alarm", 4'(a), 8'h00);
        expect_reg("R1 ctrl", 4'd12, 8'h00);
        expect_reg("R1 status", 4'd13, 8'h00);
        chk("R1 busy", {7'd0, upd_busy}, 8'h00);
        chk("R1 irq", {7'd0, alarm_irq}, 8'h00);

        // R2 divider cleared: tick ignored
        wr(4'd12, 8'h06);
        wr(4'd0, 8'h10);
        tick_wait();
        expect_reg("R2 div off", 4'd0, 8'h10);

        // R2 / R8 busy window
        wr(4'd12, 8'h16);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        bus_addr = 4'd0;
        #1;
        chk("R8 read during update", bus_rdata, 8'hFF);
        bus_addr = 4'd13;
        #1;
        chk("R8 status busy bit", bus_rdata & 8'h80, 8'h80);
        cnt = 1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (upd_busy) cnt++;
            else break;
        end
        chk("R2 busy length", 8'(cnt), 8'd9);
        expect_reg("R2 sec after", 4'd0, 8'h11);

        // R3 seconds sweep, both formats
        for (int b = 0; b < 2; b++) begin
            wr(4'd12, b ? 8'h16 : 8'h12);
            for (int s = 0; s < 60; s++) begin
                wr(4'd0, enc(s, b));
                wr(4'd1, enc(7, b));
                tick_wait();
                expect_reg("R3 sec", 4'd0, enc((s + 1) % 60, b));
                expect_reg("R3 min", 4'd1, enc(s == 59 ? 8 : 7, b));
            end
        end

        // R4 / R6 calendar sweep
        for (int mo = 1; mo <= 12; mo++) begin
            for (int yi = 0; yi < 4; yi++) begin
                for (int last = 0; last < 2; last++) begin
                    y   = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 4 : 99;
                    bin = yi % 2;
                    dm  = days_of(mo, y);
                    d   = last ? dm : dm - 1;
                    wr(4'd12, bin ? 8'h16 : 8'h12);
                    load(enc(59, bin[0]), enc(59, bin[0]), enc(23, bin[0]), enc(7, bin[0]),
                         enc(d, bin[0]), enc(mo, bin[0]), enc(y, bin[0]), enc(19, bin[0]));
                    tick_wait();
                    ed  = last ? 1 : d + 1;
                    emo = (last && mo == 12) ? 1 : (last ? mo + 1 : mo);
                    ey  = (last && mo == 12) ? (y + 1) % 100 : y;
                    ec  = (last && mo == 12 && y == 99) ? 20 : 19;
                    expect_reg("R3 sec wrap", 4'd0, enc(0, bin[0]));
                    expect_reg("R3 min wrap", 4'd1, enc(0, bin[0]));
                    expect_reg("R4 hour wrap", 4'd2, enc(0, bin[0]));
                    expect_reg("R4 dow wrap", 4'd3, enc(1, bin[0]));
                    expect_reg("R6 date", 4'd4, enc(ed, bin[0]));
                    expect_reg("R6 month", 4'd5, enc(emo, bin[0]));
                    expect_reg("R6 year", 4'd6, enc(ey, bin[0]));
                    expect_reg("R6 century", 4'd7, enc(ec, bin[0]));
                end
            end
        end

        // R6 century wrap
        wr(4'd12, 8'h12);
        load(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h99, 8'h99);
        tick_wait();
        expect_reg("R6 century 99 wrap", 4'd7, 8'h00);

        // R5 12-hour sweep
        for (int hh = 0; hh < 24; hh++) begin
            bin = hh % 2;
            h   = hh;
            hn  = (hh + 1) % 24;
            wr(4'd12, bin ? 8'h14 : 8'h10);
            load(enc(59, bin[0]), enc(59, bin[0]),
                 (h >= 12 ? 8'h80 : 8'h00) | enc((h % 12 == 0) ? 12 : h % 12, bin[0]),
                 enc(3, bin[0]), enc(10, bin[0]), enc(5, bin[0]), enc(20, bin[0]), enc(20, bin[0]));
            tick_wait();
            expect_reg("R5 hour 12h", 4'd2,
                       (hn >= 12 ? 8'h80 : 8'h00) | enc((hn % 12 == 0) ? 12 : hn % 12, bin[0]));
            expect_reg("R5 date carry", 4'd4, enc(hh == 23 ? 11 : 10, bin[0]));
            expect_reg("R5 dow carry", 4'd3, enc(hh == 23 ? 4 : 3, bin[0]));
        end

        // R7 abort in first update cycle
        wr(4'd12, 8'h16);
        wr(4'd0, 8'd10);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick  = 1'b0;
        bus_addr  = 4'd12;
        bus_wdata = 8'h96;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        chk("R7 busy after abort", {7'd0, upd_busy}, 8'h00);
        expect_reg("R7 sec untouched", 4'd0, 8'd10);
        tick_wait();
        expect_reg("R7 frozen tick", 4'd0, 8'd10);
        wr(4'd12, 8'h16);
        tick_wait();
        expect_reg("R7 resumed", 4'd0, 8'd11);

        // R11 write during update dropped
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick  = 1'b0;
        bus_addr  = 4'd0;
        bus_wdata = 8'd30;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        repeat (9) @(negedge clk);
        expect_reg("R11 write dropped", 4'd0, 8'd12);

        // R9 exact match
        wr(4'd12, 8'h16);
        load(8'd29, 8'd20, 8'd10, 8'd2, 8'd5, 8'd6, 8'd30, 8'd20);
        wr(4'd8, 8'd30); wr(4'd9, 8'd20); wr(4'd10, 8'd10); wr(4'd11, 8'd5);
        tick_wait();
        chk("R9 match fires", {7'd0, alarm_irq}, 8'h01);
        read_status(st);
        chk("R10 status shows flag", st & 8'h01, 8'h01);
        chk("R10 cleared by read", {7'd0, alarm_irq}, 8'h00);

        // R9 date mismatch
        wr(4'd0, 8'd29);
        wr(4'd11, 8'd6);
        tick_wait();
        chk("R9 mismatch silent", {7'd0, alarm_irq}, 8'h00);

        // R9 all don't-care
        wr(4'd8, 8'hC0); wr(4'd9, 8'hFF); wr(4'd10, 8'hD5); wr(4'd11, 8'hE0);
        tick_wait();
        chk("R9 dont care fires", {7'd0, alarm_irq}, 8'h01);
        read_status(st);

        // R9 partial don't-care with hour mismatch
        wr(4'd10, 8'd11); wr(4'd9, 8'd20);
        tick_wait();
        chk("R9 partial mismatch", {7'd0, alarm_irq}, 8'h00);

        // R10 set and clear in the same cycle
        wr(4'd10, 8'hC0);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        repeat (8) @(negedge clk);
        bus_addr = 4'd13;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
        #1;
        chk("R10 set wins", {7'd0, alarm_irq}, 8'h01);
        read_status(st);
        chk("R10 next read clears", {7'd0, alarm_irq}, 8'h00);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule